// File: doc/BRIEF.md
# Descriptor-Chained Frame Transmit DMA

This engine copies outgoing frames, one at a time, from a byte-wide packet buffer into a transmit FIFO. Each frame sits behind a seven-byte descriptor. The descriptor holds a little-endian link to the next descriptor, a 16-bit byte count and a 16-bit status word. Bit 15 of the status word is the ownership flag: software sets it to hand a frame to the engine, and the engine clears it when it returns the descriptor. Frame bytes follow the descriptor directly in memory.

After a start strobe, the engine checks ownership of the descriptor at its current address. It then fetches the count and link and streams the bytes into the FIFO. Next it waits for the MAC to report the frame as sent. It writes back the status, pulses a done interrupt and follows the link to the next descriptor, walking the chain until it meets a descriptor it does not own.

The FIFO controller can ask for a retry, which resends the frame from its first byte, or for an abort, which drops the frame. In both cases the engine empties the FIFO and holds until the controller has confirmed the clear and withdrawn its request.

Top module: `tx_desc_dma`

## Requirements
- R1: Descriptor layout relative to its base address: link low/high at +0/+1, byte count low/high at +3/+4, status low/high at +5/+6, frame data from +7 upward. Memory read data is valid in the cycle after a read request.
- R2: For each owned descriptor, exactly the byte count of bytes is written to the FIFO, in ascending address order. A byte count of zero writes no byte.
- R3: The engine never asserts the FIFO write while the FIFO-full input is high. A stalled byte is written once, after full drops.
- R4: After the last byte, the engine waits for tx_done. It then writes the MAC status low byte to +5, and writes the high byte to +6 with bit 7 (ownership, status bit 15) forced to 0.
- R5: After a completed write-back, done_irq is high for exactly one cycle, and the descriptor base becomes the link value.
- R6: After advancing, the engine reads the status high byte of the new descriptor. If bit 7 is set, it sends that frame without any start strobe.
- R7: When the polled ownership bit is clear, the engine goes idle and makes no memory request until start is pulsed. Start then re-polls the same descriptor.
- R8: A retry or abort request during transfer or while waiting for tx_done stops FIFO writes at once. fifo_clr stays high until clr_ack is seen. No writes and no memory access resume while retry or abort is still high.
- R9: After a retry, the engine re-reads the byte count from memory and resends the whole frame from its first byte.
- R10: Abort takes priority over retry. After an abort, the status input sampled at the request is written back with ownership cleared, done_irq is not pulsed, and the engine moves to the next descriptor without resending.
- R11: During reset, mem_req, mem_we, fifo_wr, fifo_clr and done_irq are all low. After reset the first poll uses START_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Poll strobe, acted on while idle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after request |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write byte |
| fifo_full | input | 1 | FIFO cannot accept a byte |
| fifo_clr | output | 1 | Reset FIFO read/write pointers |
| clr_ack | input | 1 | FIFO controller confirms the clear |
| retry_req | input | 1 | Resend current frame |
| abort_req | input | 1 | Drop current frame |
| tx_done | input | 1 | Frame sent, tx_status valid |
| tx_status | input | 16 | MAC transmit status |
| done_irq | output | 1 | One-cycle frame-done interrupt |

## Verification
The embedded assertions check the cycle-local rules on every clock. They cover no write into a full FIFO and no write while retry or abort is pending. They cover fifo_clr holding until it is acknowledged, and the count never stepping below zero. They also cover the ownership bit being zero in every status-high write-back and done_irq never lasting two cycles.

Only the bench scenarios show the frame-level ordering. This includes the exact byte sequence per frame, the chain walk with no start strobe, and the rewind after a retry. It also includes skipping an aborted frame without an interrupt, the zero-length case, and re-polling an unowned descriptor on start.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_OWN_RD, S_OWN_CHK, S_HDR_RD, S_HDR_CAP,
    S_XFER_RD, S_XFER_CAP, S_XFER_WR, S_WAIT_TX,
    S_CLR, S_CLR_DROP, S_WB_LO, S_WB_HI, S_ADV
  } txd_state_e;

  localparam int unsigned OFF_LINK_LO = 0;
  localparam int unsigned OFF_LINK_HI = 1;
  localparam int unsigned OFF_CNT_LO  = 3;
  localparam int unsigned OFF_CNT_HI  = 4;
  localparam int unsigned OFF_STAT_LO = 5;
  localparam int unsigned OFF_STAT_HI = 6;
  localparam int unsigned OFF_DATA    = 7;

  // header fetch order: count first, then link
  function automatic logic [2:0] hdr_offset(input logic [1:0] step);
    case (step)
      2'd0:    return 3'(OFF_CNT_LO);
      2'd1:    return 3'(OFF_CNT_HI);
      2'd2:    return 3'(OFF_LINK_LO);
      default: return 3'(OFF_LINK_HI);
    endcase
  endfunction

  function automatic logic owned(input logic [7:0] stat_hi);
    return stat_hi[7];
  endfunction

  function automatic logic [7:0] released_hi(input logic [15:0] st);
    return {1'b0, st[14:8]};
  endfunction

endpackage

// File: rtl/txd_len_cnt.sv
module txd_len_cnt #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  input  logic          dec,
  output logic          is_zero,
  output logic          is_last
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - LW'(1);
  end

  assign is_zero = (cnt_q == '0);
  assign is_last = (cnt_q == LW'(1));

  assert_dec_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !is_zero);
endmodule

// File: rtl/txd_addr_unit.sv
module txd_addr_unit
  import txd_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] START_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [AW-1:0] link,
  input  logic          frame_start,
  input  logic          step,
  output logic [AW-1:0] desc_base,
  output logic [AW-1:0] data_ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_base <= START_ADDR;
      data_ptr  <= '0;
    end else begin
      if (adv) desc_base <= link;
      if (frame_start)  data_ptr <= desc_base + AW'(OFF_DATA);
      else if (step)    data_ptr <= data_ptr + AW'(1);
    end
  end
endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma
  import txd_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] START_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          fifo_wr,
  output logic [7:0]    fifo_data,
  input  logic          fifo_full,
  output logic          fifo_clr,
  input  logic          clr_ack,
  input  logic          retry_req,
  input  logic          abort_req,
  input  logic          tx_done,
  input  logic [15:0]   tx_status,
  output logic          done_irq
);
  localparam int LW = 16;

  txd_state_e    state_q, state_d;
  logic [1:0]    step_q;
  logic [7:0]    cnt_lo_q, byte_q;
  logic [15:0]   link_q, stat_q;
  logic          abort_q;
  logic          cnt_load, cnt_dec, cnt_zero, cnt_last;
  logic          frame_start, ptr_step, adv;
  logic [AW-1:0] desc_base, data_ptr;
  logic          evt;

  assign evt = retry_req | abort_req;

  txd_len_cnt #(.LW(LW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load),
    .load_val({mem_rdata, cnt_lo_q}), .dec(cnt_dec),
    .is_zero(cnt_zero), .is_last(cnt_last)
  );

  txd_addr_unit #(.AW(AW), .START_ADDR(START_ADDR)) u_addr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .link(AW'(link_q)),
    .frame_start(frame_start), .step(ptr_step),
    .desc_base(desc_base), .data_ptr(data_ptr)
  );

  always_comb begin
    state_d = state_q;
    mem_req = 1'b0;  mem_we = 1'b0;  mem_addr = desc_base;  mem_wdata = '0;
    fifo_wr = 1'b0;  fifo_clr = 1'b0;  done_irq = 1'b0;
    cnt_load = 1'b0; cnt_dec = 1'b0; frame_start = 1'b0; ptr_step = 1'b0; adv = 1'b0;
    case (state_q)
      S_IDLE:    if (start) state_d = S_OWN_RD;
      S_OWN_RD: begin
        mem_req = 1'b1; mem_addr = desc_base + AW'(OFF_STAT_HI);
        state_d = S_OWN_CHK;
      end
      S_OWN_CHK: state_d = owned(mem_rdata) ? S_HDR_RD : S_IDLE;
      S_HDR_RD: begin
        mem_req = 1'b1; mem_addr = desc_base + AW'(hdr_offset(step_q));
        state_d = S_HDR_CAP;
      end
      S_HDR_CAP: begin
        cnt_load = (step_q == 2'd1);
        if (step_q == 2'd3) begin
          frame_start = 1'b1;
          state_d = cnt_zero ? S_WAIT_TX : S_XFER_RD;
        end else state_d = S_HDR_RD;
      end
      S_XFER_RD: begin
        if (evt) state_d = S_CLR;
        else begin
          mem_req = 1'b1; mem_addr = data_ptr; state_d = S_XFER_CAP;
        end
      end
      S_XFER_CAP: state_d = evt ? S_CLR : S_XFER_WR;
      S_XFER_WR: begin
        if (evt) state_d = S_CLR;
        else if (!fifo_full) begin
          fifo_wr = 1'b1; cnt_dec = 1'b1; ptr_step = 1'b1;
          state_d = cnt_last ? S_WAIT_TX : S_XFER_RD;
        end
      end
      S_WAIT_TX: begin
        if (evt) state_d = S_CLR;
        else if (tx_done) state_d = S_WB_LO;
      end
      S_CLR: begin
        fifo_clr = 1'b1;
        if (clr_ack) state_d = S_CLR_DROP;
      end
      S_CLR_DROP: if (!evt) state_d = abort_q ? S_WB_LO : S_HDR_RD;
      S_WB_LO: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = desc_base + AW'(OFF_STAT_LO); mem_wdata = stat_q[7:0];
        state_d = S_WB_HI;
      end
      S_WB_HI: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = desc_base + AW'(OFF_STAT_HI); mem_wdata = released_hi(stat_q);
        state_d = S_ADV;
      end
      S_ADV: begin
        done_irq = !abort_q; adv = 1'b1; state_d = S_OWN_RD;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE; step_q <= '0; cnt_lo_q <= '0; byte_q <= '0;
      link_q <= '0; stat_q <= '0; abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == S_HDR_RD && state_q != S_HDR_CAP) step_q <= '0;
      if (state_q == S_HDR_CAP) begin
        step_q <= step_q + 2'd1;
        case (step_q)
          2'd0:    cnt_lo_q      <= mem_rdata;
          2'd2:    link_q[7:0]   <= mem_rdata;
          2'd3:    link_q[15:8]  <= mem_rdata;
          default: ;
        endcase
      end
      if (state_q == S_XFER_CAP) byte_q <= mem_rdata;
      if (state_d == S_CLR && state_q != S_CLR) begin
        abort_q <= abort_req;
        if (abort_req) stat_q <= tx_status;
      end
      if (state_q == S_WAIT_TX && state_d == S_WB_LO) stat_q <= tx_status;
      if (state_q == S_ADV) abort_q <= 1'b0;
    end
  end

  assign fifo_data = byte_q;

  assert_no_write_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !fifo_full);
  assert_no_write_in_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !(retry_req || abort_req));
  assert_clr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr && !clr_ack) |=> fifo_clr);
  assert_own_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == desc_base + AW'(OFF_STAT_HI)) |-> !mem_wdata[7]);
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !start) |=> !mem_req);
endmodule

// File: tb/tx_desc_dma_bench.sv
`timescale 1ns/1ps
module tx_desc_dma_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic mem_req, mem_we, fifo_wr, fifo_clr, done_irq;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, fifo_data;
  logic [7:0]  mem_rdata = '0;
  logic fifo_full = 1'b0, clr_ack = 1'b0, retry_req = 1'b0, abort_req = 1'b0, tx_done = 1'b0;
  logic [15:0] tx_status = '0;

  always #5 clk = ~clk;

  tx_desc_dma u_tx_desc_dma (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_full(fifo_full),
    .fifo_clr(fifo_clr), .clr_ack(clr_ack), .retry_req(retry_req),
    .abort_req(abort_req), .tx_done(tx_done), .tx_status(tx_status),
    .done_irq(done_irq)
  );

  // packet buffer model, read data one cycle after request
  logic [7:0] mem [0:255];
  logic       tb_we = 1'b0;
  logic [7:0] tb_a = '0, tb_d = '0;
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
    if (tb_we) mem[tb_a] <= tb_d;
  end

  // FIFO-full pattern
  logic full_mode = 1'b0;
  int   cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 fifo_full <= full_mode && (cyc % 3 != 0);
  end

  int total = 0, bad = 0, irq_cnt = 0, req_cnt = 0, exp_idx = 0;
  int exp_q[$];
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference stream model, compared on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_irq) irq_cnt++;
      if (mem_req) req_cnt++;
      if (fifo_clr) exp_idx = 0;
      if (fifo_wr) begin
        chk(!fifo_full, "R3 write while full", 1, 0);
        chk(!(retry_req || abort_req || fifo_clr), "R8 write during event", 1, 0);
        if (exp_idx < exp_q.size()) chk(fifo_data == exp_q[exp_idx][7:0], "R2 byte", fifo_data, exp_q[exp_idx]);
        else chk(0, "R2 extra byte", fifo_data, 0);
        exp_idx++;
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wmem(input int a, input int d);
    tb_a = a[7:0]; tb_d = d[7:0]; tb_we = 1'b1; tick(); tb_we = 1'b0;
  endtask

  task automatic set_desc(input int base, input int link, input int len, input bit own, input int seed);
    wmem(base + 0, link & 8'hff); wmem(base + 1, link >> 8);
    wmem(base + 3, len & 8'hff);  wmem(base + 4, len >> 8);
    wmem(base + 5, 0);            wmem(base + 6, own ? 8'h80 : 8'h00);
    for (int i = 0; i < len; i++) wmem(base + 7 + i, (seed + i) & 8'hff);
  endtask

  task automatic load_frame(input int len, input int seed);
    exp_q.delete();
    for (int i = 0; i < len; i++) exp_q.push_back((seed + i) & 8'hff);
    exp_idx = 0;
  endtask

  task automatic wait_bytes(input int n, input string tag);
    int t = 0;
    while (exp_idx < n && t < 3000) begin tick(); t++; end
    chk(exp_idx >= n, tag, exp_idx, n);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(); s = 1'b0;
  endtask

  task automatic wait_clr();
    int t = 0;
    while (!fifo_clr && t < 200) begin tick(); t++; end
    chk(fifo_clr, "R8 clear raised", fifo_clr, 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int r0;
    tick(4);
    @(negedge clk);
    chk(!mem_req && !mem_we && !fifo_wr && !fifo_clr && !done_irq, "R11 reset outputs",
        {mem_req, mem_we, fifo_wr, fifo_clr, done_irq}, 0);
    tick(); rst_n = 1'b1;

    set_desc(8'h00, 8'h20, 4, 1, 8'h10);
    set_desc(8'h20, 8'h40, 8, 1, 8'h30);
    set_desc(8'h40, 8'h60, 6, 0, 8'h50);
    set_desc(8'h60, 8'h80, 5, 1, 8'h70);
    set_desc(8'h80, 8'hA0, 3, 1, 8'h90);
    set_desc(8'hA0, 8'hC0, 0, 1, 0);
    set_desc(8'hC0, 8'hE0, 2, 0, 8'hB0);

    // R1 R2: first frame from START_ADDR
    load_frame(4, 8'h10); tx_status = 16'hC0A5;
    pulse(start);
    wait_bytes(4, "R2 frame0 bytes");
    tick(3); chk(exp_idx == 4, "R4 waits for tx_done", exp_idx, 4);
    pulse(tx_done);
    load_frame(8, 8'h30); full_mode = 1'b1;
    tick(6);
    chk(irq_cnt == 1, "R5 done pulse", irq_cnt, 1);
    chk(mem[8'h05] == 8'hA5, "R4 status low", mem[8'h05], 8'hA5);
    chk(mem[8'h06] == 8'h40, "R4 status high own cleared", mem[8'h06], 8'h40);

    // R6 R3: chained frame with FIFO stalls, no start
    wait_bytes(8, "R6 chained frame bytes");
    full_mode = 1'b0; tx_status = 16'h8011;
    pulse(tx_done); tick(8);
    chk(irq_cnt == 2, "R5 second pulse", irq_cnt, 2);
    chk(mem[8'h26] == 8'h00 && mem[8'h25] == 8'h11, "R4 frame1 status", {mem[8'h26], mem[8'h25]}, 16'h0011);

    // R7: unowned descriptor stays idle
    tick(20); r0 = req_cnt; tick(30);
    chk(req_cnt == r0, "R7 idle no access", req_cnt - r0, 0);

    // R8 R9: retry on frame at 0x40
    wmem(8'h46, 8'h80);
    load_frame(6, 8'h50);
    pulse(start);
    wait_bytes(2, "R9 partial before retry");
    retry_req = 1'b1;
    wait_clr();
    tick(3); chk(fifo_clr, "R8 clear held until ack", fifo_clr, 1);
    clr_ack = 1'b1; tick(); clr_ack = 1'b0;
    r0 = req_cnt; tick(4);
    chk(!fifo_clr, "R8 clear released", fifo_clr, 0);
    chk(req_cnt == r0, "R8 no resume while retry", req_cnt - r0, 0);
    retry_req = 1'b0;
    wait_bytes(6, "R9 full resend from first byte");
    tx_status = 16'h8002;
    pulse(tx_done);
    load_frame(5, 8'h70);
    tick(6);
    chk(irq_cnt == 3, "R5 pulse after retry", irq_cnt, 3);

    // R10: abort (with retry) on frame at 0x60
    wait_bytes(3, "R10 partial before abort");
    tx_status = 16'hFF33; abort_req = 1'b1; retry_req = 1'b1;
    wait_clr();
    clr_ack = 1'b1; tick(); clr_ack = 1'b0;
    tick(2); abort_req = 1'b0; retry_req = 1'b0;
    load_frame(3, 8'h90);
    wait_bytes(3, "R10 next frame without resend");
    chk(irq_cnt == 3, "R10 no pulse on abort", irq_cnt, 3);
    chk(mem[8'h65] == 8'h33, "R10 abort status low", mem[8'h65], 8'h33);
    chk(mem[8'h66] == 8'h7F, "R10 abort status own cleared", mem[8'h66], 8'h7F);
    tx_status = 16'h8044;
    pulse(tx_done);
    load_frame(0, 0);
    tick(6);
    chk(irq_cnt == 4, "R5 pulse frame 0x80", irq_cnt, 4);

    // R2: zero-length frame at 0xA0
    tick(30);
    chk(exp_idx == 0, "R2 zero length no bytes", exp_idx, 0);
    pulse(tx_done); tick(8);
    chk(irq_cnt == 5, "R2 zero length completes", irq_cnt, 5);
    chk(mem[8'hA5] == 8'h44, "R4 zero length status", mem[8'hA5], 8'h44);

    // R7: start re-polls unowned descriptor at 0xC0 once
    tick(20); r0 = req_cnt; tick(20);
    chk(req_cnt == r0, "R7 idle at chain end", req_cnt - r0, 0);
    pulse(start); tick(10);
    chk(req_cnt - r0 == 1, "R7 start re-polls once", req_cnt - r0, 1);
    chk(exp_idx == 0, "R7 unowned not sent", exp_idx, 0);

    summary();
  end
endmodule